// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose parallel port with up to 32 pins behind a small word-addressed register bus. Software picks the direction of each pin, drives output levels through an output latch, reads the synchronised pin levels, and enables interrupts per pin. Each pin input passes through a two-stage synchroniser. Transitions are then found by comparing the synchronised value with its value one cycle earlier. The transitions of the kind the build selects are latched into a sticky capture register, and software clears it by writing ones to it.

The trigger kind is a build parameter with four values: rising, falling, either edge, or level high. It cannot be changed at run time. A single interrupt line merges all pins. In the edge kinds it is the OR of the captured events that are enabled. In level-high kind it is the OR of the enabled synchronised pin levels, and the capture register stays empty.

The bus has no back-pressure. A write strobe commits on the clock edge where it is sampled high. Read data is combinational from the word index, so it needs no handshake.

Top module: `pio_edge_core`

## Requirements
- R1: After reset, the direction, enable and capture registers and the output latch all read zero: every pin is an input, `pin_oe` and `pin_out` are zero, and `irq` is low.
- R2: The pin count is `PIN_REQ` limited to the range 1..32. Register bits at or above that count always read zero, and writing them has no effect.
- R3: Word index 1 (byte offset 0x4) holds the direction. A 1 bit makes the pin an output, and `pin_oe` follows that bit on the cycle after the write. The register reads back what was written.
- R4: Word index 0 (byte offset 0x0) is the data word. A write loads the output latch, and the latch appears on `pin_out` on the next cycle. A read returns the synchronised pin inputs: a level applied before clock edge k is readable after edge k+1.
- R5: Word index 2 (byte offset 0x8) holds the interrupt enables. A 1 bit enables the pin, and the register reads back. While all enables are zero, `irq` stays low.
- R6: Word index 3 (byte offset 0xC) is the capture register. Its bits are sticky. A write clears each bit written as 1 and keeps each bit written as 0.
- R7: A pin change applied before edge k sets its capture bit at edge k+2, and `irq` rises in that same cycle if the pin is enabled. The bit is still clear after edge k+1.
- R8: The build selects which transitions are captured: 0→1 only in rising kind, 1→0 only in falling kind, and both in either-edge kind.
- R9: In level-high kind, `irq` equals the OR of (synchronised inputs AND enables) from the cycle after edge k+1, and the capture register stays zero.
- R10: If a capture bit gets a new event in the same cycle that a write clears it, the bit ends up set.
- R11: In the edge kinds, `irq` is high exactly when some capture bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, commits at the rising edge |
| bus_addr | input | 2 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NP | Pin input levels (asynchronous) |
| pin_out | output | NP | Output latch |
| pin_oe | output | NP | Per-pin output enable (1 = drive) |
| irq | output | 1 | Merged interrupt |

## Verification
The bench builds four copies that share one bus and one set of pin drivers. The first is the either-edge kind with `PIN_REQ`=40, which checks that the count is limited to 32 pins. The others are the rising kind with 5 pins, the falling kind with 12 pins, and the level-high kind with 8 pins. Because of these narrow widths, upper-bit masking can be seen on reads, and one pin transition produces a different capture result in each trigger kind. The directed cases are the capture latency of two edges and a clear write that collides with a new event.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int MAX_PINS = 32;
  localparam int BUS_W    = 32;

  typedef enum logic [1:0] {
    IDX_DATA = 2'd0,
    IDX_DIR  = 2'd1,
    IDX_MASK = 2'd2,
    IDX_CAP  = 2'd3
  } reg_idx_e;

  function automatic int clamp_pins(int req);
    if (req < 1) return 1;
    if (req > MAX_PINS) return MAX_PINS;
    return req;
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/pio_edge_capture.sv
module pio_edge_capture
  import pio_pkg::*;
#(
  parameter int    W    = 32,
  parameter trig_e TRIG = TRIG_BOTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] cap
);
  logic [W-1:0] prev_q, evt, cap_q, cap_d;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  generate
    if (TRIG == TRIG_RISE) begin : g_rise
      assign evt = level & ~prev_q;
    end else if (TRIG == TRIG_FALL) begin : g_fall
      assign evt = ~level & prev_q;
    end else if (TRIG == TRIG_BOTH) begin : g_both
      assign evt = level ^ prev_q;
    end else begin : g_none
      assign evt = '0;
    end
  endgenerate

  // A new event outranks a clear of the same bit.
  always_comb begin
    cap_d = cap_q;
    if (clr_en) cap_d = cap_d & ~clr_bits;
    cap_d = cap_d | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap = cap_q;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   idx,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] msk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      msk_q <= '0;
    end else if (wr) begin
      case (reg_idx_e'(idx))
        IDX_DATA: out_q <= wdata;
        IDX_DIR:  dir_q <= wdata;
        IDX_MASK: msk_q <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pio_edge_core.sv
module pio_edge_core
  import pio_pkg::*;
#(
  parameter int    PIN_REQ = 32,
  parameter trig_e TRIG    = TRIG_BOTH
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_wr,
  input  logic [1:0]                         bus_addr,
  input  logic [BUS_W-1:0]                   bus_wdata,
  output logic [BUS_W-1:0]                   bus_rdata,
  input  logic [pio_pkg::clamp_pins(PIN_REQ)-1:0] pin_in,
  output logic [pio_pkg::clamp_pins(PIN_REQ)-1:0] pin_out,
  output logic [pio_pkg::clamp_pins(PIN_REQ)-1:0] pin_oe,
  output logic                               irq
);
  localparam int NP = clamp_pins(PIN_REQ);

  logic [NP-1:0] sync_lv, cap_q, out_q, dir_q, msk_q, wd_np;
  logic          clr_en;

  assign wd_np  = bus_wdata[NP-1:0];
  assign clr_en = bus_wr && (reg_idx_e'(bus_addr) == IDX_CAP);

  pio_sync #(.W(NP)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(sync_lv)
  );

  pio_edge_capture #(.W(NP), .TRIG(TRIG)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(sync_lv),
    .clr_en(clr_en), .clr_bits(wd_np), .cap(cap_q)
  );

  pio_regs #(.W(NP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .idx(bus_addr), .wdata(wd_np),
    .out_q(out_q), .dir_q(dir_q), .msk_q(msk_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (reg_idx_e'(bus_addr))
      IDX_DATA: bus_rdata[NP-1:0] = sync_lv;
      IDX_DIR:  bus_rdata[NP-1:0] = dir_q;
      IDX_MASK: bus_rdata[NP-1:0] = msk_q;
      default:  bus_rdata[NP-1:0] = cap_q;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  generate
    if (TRIG == TRIG_LEVEL) begin : g_irq_lvl
      assign irq = |(sync_lv & msk_q);
    end else begin : g_irq_edge
      assign irq = |(cap_q & msk_q);
    end
  endgenerate
endmodule

// File: rtl/pio_edge_core_chk.sv
module pio_edge_core_chk
  import pio_pkg::*;
#(
  parameter int    W    = 32,
  parameter trig_e TRIG = TRIG_BOTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [W-1:0]     pin_out,
  input logic [W-1:0]     pin_oe,
  input logic             irq,
  input logic [W-1:0]     cap,
  input logic [W-1:0]     msk
);
  localparam logic [BUS_W-1:0] LOW = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LOW) == '0); // R2
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> pin_oe == $past(bus_wdata[W-1:0])); // R3
  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> pin_out == $past(bus_wdata[W-1:0])); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '0) |-> !irq); // R5
  AST_CAP_KEEP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=>
      ((cap & $past(cap) & ~$past(bus_wdata[W-1:0])) == ($past(cap) & ~$past(bus_wdata[W-1:0])))); // R6
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd3) |=> ((cap & $past(cap)) == $past(cap))); // R6
  AST_LEVEL_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (TRIG == TRIG_LEVEL) |-> cap == '0); // R9
endmodule

bind pio_edge_core pio_edge_core_chk #(.W(NP), .TRIG(TRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .cap(cap_q), .msk(msk_q)
);

// File: tb/pio_edge_core_test.sv
module pio_edge_core_test;
  import pio_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rd [4];
  logic        irqv [4];
  logic [31:0] po0, oe0;
  logic [4:0]  po1, oe1;
  logic [11:0] po2, oe2;
  logic [7:0]  po3, oe3;
  int          n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_edge_core #(.PIN_REQ(40), .TRIG(TRIG_BOTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[0]), .pin_in(pins), .pin_out(po0), .pin_oe(oe0), .irq(irqv[0]));
  pio_edge_core #(.PIN_REQ(5), .TRIG(TRIG_RISE)) uut_rise (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[1]), .pin_in(pins[4:0]), .pin_out(po1), .pin_oe(oe1), .irq(irqv[1]));
  pio_edge_core #(.PIN_REQ(12), .TRIG(TRIG_FALL)) uut_fall (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[2]), .pin_in(pins[11:0]), .pin_out(po2), .pin_oe(oe2), .irq(irqv[2]));
  pio_edge_core #(.PIN_REQ(8), .TRIG(TRIG_LEVEL)) uut_lvl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd[3]), .pin_in(pins[7:0]), .pin_out(po3), .pin_oe(oe3), .irq(irqv[3]));

  trig_e       mode [4] = '{TRIG_BOTH, TRIG_RISE, TRIG_FALL, TRIG_LEVEL};
  logic [31:0] lowm [4] = '{32'hFFFF_FFFF, 32'h1F, 32'hFFF, 32'hFF};
  logic [31:0] cap_m [4];
  logic [31:0] msk_m [4];

  function automatic logic [31:0] events(trig_e m, logic [31:0] o, logic [31:0] n);
    case (m)
      TRIG_RISE: return n & ~o;
      TRIG_FALL: return o & ~n;
      TRIG_BOTH: return n ^ o;
      default:   return '0;
    endcase
  endfunction

  function automatic logic exp_irq(int i);
    if (mode[i] == TRIG_LEVEL) return |(pins & msk_m[i] & lowm[i]);
    return |(cap_m[i] & msk_m[i]);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic sel(logic [1:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic apply_pins(logic [31:0] v);
    logic [31:0] old;
    old = pins;
    pins = v;
    step(3);
    for (int i = 0; i < 4; i++) cap_m[i] |= events(mode[i], old, v) & lowm[i];
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 4; i++) begin
      sel(2'd0); chk(req, "data read", rd[i], pins & lowm[i]);
      sel(2'd3); chk(req, "capture read", rd[i], cap_m[i]);
      sel(2'd2); chk(req, "mask read", rd[i], msk_m[i]);
      chk(req, "irq", 32'(irqv[i]), 32'(exp_irq(i)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) begin cap_m[i] = '0; msk_m[i] = '0; end
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      sel(2'd1); chk("R1", "dir after reset", rd[i], 32'h0);
      sel(2'd2); chk("R1", "mask after reset", rd[i], 32'h0);
      sel(2'd3); chk("R1", "capture after reset", rd[i], 32'h0);
      chk("R1", "irq after reset", 32'(irqv[i]), 32'h0);
    end
    chk("R1", "pin_oe after reset", oe0, 32'h0);
    chk("R1", "pin_out after reset", po0, 32'h0);

    // R3, R2: direction and pin-count limit
    bwrite(2'd1, 32'hFFFF_FFFF);
    chk("R3", "pin_oe all out", oe0, 32'hFFFF_FFFF);
    sel(2'd1); chk("R2", "dir width 5", rd[1], 32'h1F);
    chk("R2", "dir width 12", rd[2], 32'hFFF);
    chk("R2", "dir width 40 clamped", rd[0], 32'hFFFF_FFFF);
    bwrite(2'd1, 32'h0000_00A5);
    chk("R3", "pin_oe pattern", oe0, 32'hA5);
    chk("R3", "pin_oe narrow", 32'(oe1), 32'h05);

    // R4: output latch
    bwrite(2'd0, 32'hDEAD_BEEF);
    chk("R4", "pin_out", po0, 32'hDEAD_BEEF);
    chk("R4", "pin_out narrow", 32'(po2), 32'hEEF);

    // R5: enable all
    bwrite(2'd2, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) msk_m[i] = lowm[i];

    // R7, R4, R9: latency of a rising pin 0
    pins = 32'h1;
    step(1);
    sel(2'd0); chk("R4", "data not yet visible after one edge", rd[0], 32'h0);
    step(1);
    sel(2'd0); chk("R4", "data visible after second edge", rd[0], 32'h1);
    sel(2'd3); chk("R7", "capture still clear after second edge", rd[0], 32'h0);
    chk("R9", "level irq with data", 32'(irqv[3]), 32'h1);
    step(1);
    sel(2'd3); chk("R7", "capture set after third edge", rd[0], 32'h1);
    chk("R7", "irq with capture", 32'(irqv[0]), 32'h1);
    chk("R8", "rise kind sees rising", rd[1], 32'h1);
    chk("R8", "fall kind ignores rising", rd[2], 32'h0);
    chk("R9", "level kind capture stays zero", rd[3], 32'h0);
    cap_m[0] = 32'h1; cap_m[1] = 32'h1;

    // R8: falling pin 0
    apply_pins(32'h0);
    check_all("R8");

    // R6: clear bit 0 only on a set
    bwrite(2'd3, 32'h0000_0001);
    for (int i = 0; i < 4; i++) cap_m[i] &= ~32'h1;
    check_all("R6");

    // R10: collision of a new event with a clear
    apply_pins(32'h2);
    pins = 32'h3;
    step(2);
    bwrite(2'd3, 32'hFFFF_FFFF);
    sel(2'd3);
    chk("R10", "new edge survives clear (both)", rd[0], 32'h1);
    chk("R10", "new edge survives clear (rise)", rd[1], 32'h1);
    chk("R10", "falling kind cleared", rd[2], 32'h0);
    cap_m[0] = 32'h1; cap_m[1] = 32'h1; cap_m[2] = 32'h0;

    // R5, R11: masked capture keeps irq low
    bwrite(2'd2, 32'h0);
    for (int i = 0; i < 4; i++) msk_m[i] = '0;
    check_all("R5");

    // R11 and others under random stimulus
    for (int it = 0; it < 80; it++) begin
      logic [31:0] r;
      apply_pins($urandom);
      check_all("R11");
      if ($urandom_range(1, 0) == 1) begin
        r = $urandom;
        bwrite(2'd2, r);
        for (int i = 0; i < 4; i++) msk_m[i] = r & lowm[i];
      end
      if ($urandom_range(1, 0) == 1) begin
        r = $urandom;
        bwrite(2'd3, r);
        for (int i = 0; i < 4; i++) cap_m[i] &= ~r;
        check_all("R6");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule